// File: doc/BRIEF.md
# Multi-Mode Programmable Down-Counter Channel

This block is one down-counting timer channel of `W` bits (16 by default). The counter does not run on the system clock. It steps once on each high-to-low transition of an external count-clock pin. That pin is sampled on the system clock, so it must be slow compared with the system clock. A gate pin, qualified by the selected mode, can pause, arm or restart the count. A single output pin carries the mode's waveform: a terminal-count flag, a one-shot pulse, a rate tick, a square wave or a strobe.

Software, or a neighbouring host-interface block, sets up the channel in two steps:

- A program strobe chooses the mode and clears the channel.
- A load strobe supplies a start value, called the preset.

The live count is visible at all times. A load error flag reports a preset that the current mode refuses.

Top module: `tmr_channel`

## Requirements
- R1: After reset the count is 0, the output pin is low, the load error flag is low and the mode is 0.
- R2: The count changes only in the system-clock cycle that follows a high-to-low transition of `ext_clk_i` (a "tick"), or on a program strobe. Every mode except 3 steps down by one per tick.
- R3: Mode codes are: 0 terminal-count flag, 1 gate-retriggered one-shot, 2 rate tick, 3 square wave, 4 software strobe, 5 gate-triggered strobe. Codes 6 and 7 behave exactly as 2 and 3.
- R4: A program strobe does the following, and has priority over a load in the same cycle:
  - it stores the mode;
  - it clears the stored preset and the count to 0;
  - it clears the error flag and drops any pending load or trigger;
  - it drives the output low in mode 0 and high in every other mode.
- R5: In modes 2 and 3, a load of the value 1 sets the error flag and leaves the stored preset unchanged. Any accepted load clears the flag.
- R6: Mode 0:
  - the first tick after a load copies the preset into the count;
  - after that, each tick with the gate high decrements the count;
  - the output is low from the load until the count reaches 0, then goes high;
  - the count halts at 0.
- R7: Mode 4 counts as mode 0 does. Its output stays high except for one tick period, which starts when the count reaches 0.
- R8: Modes 1 and 5:
  - a load alone does not start the count;
  - a gate rising edge, once a preset is held, makes the next tick copy the preset into the count;
  - a further gate rising edge during the count restarts it;
  - the gate level has no effect;
  - in mode 1 the output is low from that copy until the count reaches 0;
  - in mode 5 the output behaves as in mode 4.
- R9: Mode 2:
  - the count runs from the preset down to 1, and the next tick reloads the preset;
  - the output is low exactly while the count is 1;
  - a preset of 0 loads as 0 and the next tick gives all-ones.
- R10: Mode 3:
  - the count steps down by two, and an odd preset starts from the preset minus one;
  - a preset of 0 starts from all-ones minus one;
  - the tick that finds the count at 2 reloads it and inverts the output.
- R11: Gate low holds the count in modes 0, 2, 3 and 4. In modes 2 and 3, gate low also forces the output high, and a gate rising edge makes the next tick restart the count from the preset.
- R12: Gate edges have no effect in modes 0 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | Count-clock pin; a falling transition is one tick |
| gate_i | input | 1 | Gate pin |
| mode_i | input | 3 | Mode code, taken on a program strobe |
| prog_i | input | 1 | Program strobe |
| preset_i | input | W | Preset value, taken on a load strobe |
| load_i | input | 1 | Load strobe |
| count_o | output | W | Live count |
| out_o | output | 1 | Channel output pin |
| load_err_o | output | 1 | Refused-preset flag |

## Verification
The bench goes after four kinds of corner case, each with a distinct failure symptom:

- **Reload boundaries.** These are a rate tick reloading after 1, a square wave reloading after 2, and presets 0, 1 and odd values. A design that reloads one step late would show a period one tick too long. A design that does not trim odd presets would leave an odd count in the square-wave mode.
- **Refused preset of 1.** A design that stored this value would lock the rate mode into reloading 1 forever.
- **Gate behaviour.** The bench checks pause, forced-high output, restart and the one-shot retrigger. It also checks gate edges in the modes that must ignore them. A design that let an edge leak into mode 0 would restart a finished count.
- **Random rate and square-wave runs.** These compare every tick against closed-form count and phase formulas, to catch off-by-one errors in the period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    M_TERM    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } tmode_e;

  // codes 6 and 7 alias the two periodic modes
  function automatic tmode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd0:    return M_TERM;
      3'd1:    return M_ONESHOT;
      3'd2:    return M_RATE;
      3'd3:    return M_SQUARE;
      3'd4:    return M_SWSTB;
      3'd5:    return M_HWSTB;
      3'd6:    return M_RATE;
      default: return M_SQUARE;
    endcase
  endfunction

  function automatic logic is_periodic(input tmode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

  // modes started only by a gate rising edge
  function automatic logic is_gate_started(input tmode_e m);
    return (m == M_ONESHOT) || (m == M_HWSTB);
  endfunction

  // modes in which a gate rising edge acts as a trigger
  function automatic logic is_gate_trig(input tmode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTB);
  endfunction

  function automatic logic is_strobe(input tmode_e m);
    return (m == M_SWSTB) || (m == M_HWSTB);
  endfunction

endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic edge_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_o = sig_i & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~sig_i & prev_q;
    end
  endgenerate

endmodule

// File: rtl/tmr_start_val.sv
module tmr_start_val
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  tmode_e         mode_i,
  input  logic [W-1:0]   preset_i,
  output logic [W-1:0]   start_o
);

  localparam logic [W-1:0] TOP_EVEN = {{(W-1){1'b1}}, 1'b0};

  always_comb begin
    start_o = preset_i;
    if (mode_i == M_SQUARE) begin
      if (preset_i == '0) start_o = TOP_EVEN;
      else                start_o = {preset_i[W-1:1], 1'b0};
    end
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_clk_i,
  input  logic         gate_i,
  input  logic [2:0]   mode_i,
  input  logic         prog_i,
  input  logic [W-1:0] preset_i,
  input  logic         load_i,
  output logic [W-1:0] count_o,
  output logic         out_o,
  output logic         load_err_o
);

  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // pin edge events
  logic clk_fall;
  logic gate_rise;

  tmr_edge_det #(.RISING(1'b0)) u_clk_edge (
    .clk   (clk),
    .rst_n (rst_core_n),
    .sig_i (ext_clk_i),
    .edge_o(clk_fall)
  );

  tmr_edge_det #(.RISING(1'b1)) u_gate_edge (
    .clk   (clk),
    .rst_n (rst_core_n),
    .sig_i (gate_i),
    .edge_o(gate_rise)
  );

  // state
  tmode_e       mode_q,   mode_d;
  logic [W-1:0] preset_q, preset_d;
  logic [W-1:0] cnt_q,    cnt_d;
  logic         out_q,    out_d;
  logic         err_q,    err_d;
  logic         run_q,    run_d;
  logic         pend_q,   pend_d;
  logic         trig_q,   trig_d;
  logic         held_q,   held_d;

  logic [W-1:0] start_val;
  tmode_e       mode_new;
  logic         count_en;
  logic         load_bad;

  tmr_start_val #(.W(W)) u_start (
    .mode_i  (mode_q),
    .preset_i(preset_q),
    .start_o (start_val)
  );

  assign mode_new = decode_mode(mode_i);
  assign count_en = gate_i | is_gate_started(mode_q);
  assign load_bad = is_periodic(mode_q) && (preset_i == ONE);

  // next state
  always_comb begin
    mode_d   = mode_q;
    preset_d = preset_q;
    cnt_d    = cnt_q;
    out_d    = out_q;
    err_d    = err_q;
    run_d    = run_q;
    pend_d   = pend_q;
    trig_d   = trig_q;
    held_d   = held_q;

    if (prog_i) begin
      mode_d   = mode_new;
      preset_d = '0;
      cnt_d    = '0;
      err_d    = 1'b0;
      run_d    = 1'b0;
      pend_d   = 1'b0;
      trig_d   = 1'b0;
      held_d   = 1'b0;
      out_d    = (mode_new != M_TERM);
    end else begin
      // count events
      if (clk_fall) begin
        if (pend_q || trig_q) begin
          cnt_d  = start_val;
          run_d  = 1'b1;
          pend_d = 1'b0;
          trig_d = 1'b0;
          out_d  = !((mode_q == M_TERM) || (mode_q == M_ONESHOT));
        end else if (run_q && count_en) begin
          case (mode_q)
            M_RATE: begin
              if (cnt_q == ONE) begin
                cnt_d = start_val;
                out_d = 1'b1;
              end else begin
                cnt_d = cnt_q - ONE;
                out_d = (cnt_q != TWO);
              end
            end
            M_SQUARE: begin
              if (cnt_q == TWO) begin
                cnt_d = start_val;
                out_d = ~out_q;
              end else begin
                cnt_d = cnt_q - TWO;
              end
            end
            default: begin
              cnt_d = cnt_q - ONE;
              if (cnt_q == ONE) begin
                run_d = 1'b0;
                out_d = !is_strobe(mode_q);
              end
            end
          endcase
        end else if (!run_q && is_strobe(mode_q) && !out_q) begin
          out_d = 1'b1;
        end
      end

      // preset loads
      if (load_i) begin
        if (load_bad) begin
          err_d = 1'b1;
        end else begin
          preset_d = preset_i;
          err_d    = 1'b0;
          held_d   = 1'b1;
          if (!is_gate_started(mode_q)) pend_d = 1'b1;
          if (mode_q == M_TERM) begin
            out_d = 1'b0;
            run_d = 1'b0;
          end
        end
      end

      // gate effects
      if (gate_rise && held_d && is_gate_trig(mode_q)) trig_d = 1'b1;
      if (is_periodic(mode_q) && !gate_i) out_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      mode_q   <= M_TERM;
      preset_q <= '0;
      cnt_q    <= '0;
      out_q    <= 1'b0;
      err_q    <= 1'b0;
      run_q    <= 1'b0;
      pend_q   <= 1'b0;
      trig_q   <= 1'b0;
      held_q   <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      preset_q <= preset_d;
      cnt_q    <= cnt_d;
      out_q    <= out_d;
      err_q    <= err_d;
      run_q    <= run_d;
      pend_q   <= pend_d;
      trig_q   <= trig_d;
      held_q   <= held_d;
    end
  end

  assign count_o    = cnt_q;
  assign out_o      = out_q;
  assign load_err_o = err_q;

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_i,
  input logic         prog_i,
  input logic         load_i,
  input logic         gate_i,
  input logic [2:0]   mode_q,
  input logic [W-1:0] preset_i,
  input logic [W-1:0] preset_q,
  input logic [W-1:0] count_o,
  input logic         out_o,
  input logic         err_o
);

  localparam logic [W-1:0] ONE = W'(1);

  // R2: count moves only after a tick or a program strobe
  assert_count_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count_o) |-> $past(tick_i || prog_i))
    else $error("count changed without tick");

  // R4: program strobe clears count and error flag
  assert_prog_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_i |=> (count_o == '0) && !err_o)
    else $error("program strobe did not clear");

  // R5: refused preset of 1 in periodic modes
  assert_refuse_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !prog_i && (mode_q == 3'd2 || mode_q == 3'd3) && preset_i == ONE)
    |=> err_o && $stable(preset_q))
    else $error("preset of 1 accepted");

  // R9: rate mode output low only while count is 1
  assert_rate_low_at_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd2 && !out_o) |-> count_o == ONE)
    else $error("rate output low away from 1");

  // R10: square-wave count always even
  assert_square_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd3) |-> !count_o[0])
    else $error("odd count in square mode");

  // R11: gate low forces output high in periodic modes
  assert_gate_low_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 3'd2 || mode_q == 3'd3) && $past(!gate_i) && $past(mode_q) == mode_q)
    |-> out_o)
    else $error("output low with gate low");

endmodule

bind tmr_channel tmr_channel_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .tick_i  (clk_fall),
  .prog_i  (prog_i),
  .load_i  (load_i),
  .gate_i  (gate_i),
  .mode_q  (mode_q),
  .preset_i(preset_i),
  .preset_q(preset_q),
  .count_o (count_o),
  .out_o   (out_o),
  .err_o   (load_err_o)
);

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;

  localparam int W          = 16;
  localparam int CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         ext_clk;
  logic         gate;
  logic [2:0]   mode;
  logic         prog;
  logic [W-1:0] preset;
  logic         load;
  logic [W-1:0] count;
  logic         out;
  logic         load_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  tmr_channel #(.W(W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_clk_i (ext_clk),
    .gate_i    (gate),
    .mode_i    (mode),
    .prog_i    (prog),
    .preset_i  (preset),
    .load_i    (load),
    .count_o   (count),
    .out_o     (out),
    .load_err_o(load_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    ext_clk = 1'b1;
    repeat (2) @(negedge clk);
    ext_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_prog(input logic [2:0] m);
    mode = m; prog = 1'b1;
    @(negedge clk);
    prog = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_load(input logic [W-1:0] v);
    preset = v; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_gate(input logic g);
    gate = g;
    repeat (2) @(negedge clk);
  endtask

  // closed-form expectations for the periodic modes, k ticks after the loading tick
  function automatic int exp_cnt(input int m, input int p, input int k);
    int s, half;
    if (m == 2) return p - (k % p);
    s = p & ~1; half = s / 2;
    return s - 2 * (k % half);
  endfunction

  function automatic int exp_out(input int m, input int p, input int k);
    int s, half;
    if (m == 2) return (exp_cnt(m, p, k) != 1) ? 1 : 0;
    s = p & ~1; half = s / 2;
    return ((k / half) % 2 == 0) ? 1 : 0;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ext_clk = 1'b0; gate = 1'b1; mode = '0;
    prog = 1'b0; preset = '0; load = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 out", out, 0);
    chk("R1 err", load_err, 0);

    // R6 terminal-count flag
    do_prog(3'd0);
    do_load(16'd5);
    chk("R6 out low after load", out, 0);
    tick(); chk("R6 first tick loads", count, 5); chk("R2 load tick no decrement", out, 0);
    tick(); tick(); tick(); chk("R2 decrement by one", count, 2);
    set_gate(1'b0);
    tick(); tick(); chk("R11 gate low holds mode 0", count, 2);
    set_gate(1'b1);
    tick(); chk("R6 count 1", count, 1); chk("R6 out still low", out, 0);
    tick(); chk("R6 count 0", count, 0); chk("R6 out high at 0", out, 1);
    tick(); chk("R6 halts at 0", count, 0);
    set_gate(1'b0); set_gate(1'b1);
    tick(); chk("R12 gate edge ignored mode 0", count, 0); chk("R12 out unchanged", out, 1);

    // R7 software strobe
    do_prog(3'd4);
    chk("R4 out high mode 4", out, 1);
    do_load(16'd2);
    tick(); chk("R7 load", count, 2); chk("R7 out high", out, 1);
    set_gate(1'b0); set_gate(1'b1);
    tick(); chk("R12 mode 4 edge ignored", count, 1); chk("R7 out high", out, 1);
    tick(); chk("R7 count 0", count, 0); chk("R7 strobe low", out, 0);
    tick(); chk("R7 strobe ends", out, 1); chk("R7 stays 0", count, 0);

    // R9 rate tick, R5 refusal, R11 gate
    do_prog(3'd2);
    chk("R4 out high mode 2", out, 1);
    do_load(16'd4);
    tick(); chk("R9 load", count, 4); chk("R9 out high", out, 1);
    tick(); chk("R9 step", count, 3);
    tick(); chk("R9 step", count, 2); chk("R9 out high at 2", out, 1);
    tick(); chk("R9 at 1", count, 1); chk("R9 out low at 1", out, 0);
    tick(); chk("R9 reload", count, 4); chk("R9 out high after reload", out, 1);
    do_load(16'd1);
    chk("R5 err on 1", load_err, 1);
    tick(); chk("R5 count unaffected", count, 3);
    tick(); tick(); chk("R9 at 1 again", count, 1);
    set_gate(1'b0);
    chk("R11 gate low forces high", out, 1);
    tick(); chk("R11 gate low holds", count, 1);
    set_gate(1'b1);
    tick(); chk("R11 restart, R5 preset kept", count, 4);
    do_load(16'd3);
    chk("R5 accepted load clears err", load_err, 0);
    tick(); chk("R9 new preset", count, 3);

    // R3 alias codes
    do_prog(3'd6);
    do_load(16'd1);
    chk("R3 code 6 refuses 1", load_err, 1);
    do_load(16'd3);
    tick(); tick(); tick(); chk("R3 code 6 at 1", count, 1); chk("R3 code 6 out low", out, 0);
    tick(); chk("R3 code 6 reload", count, 3);
    do_prog(3'd7);
    do_load(16'd5);
    tick(); chk("R3 code 7 trims odd", count, 4);
    tick(); chk("R3 code 7 step 2", count, 2);
    tick(); chk("R3 code 7 reload", count, 4); chk("R3 code 7 toggles", out, 0);

    // R9 preset 0 wrap
    do_prog(3'd2);
    do_load(16'd0);
    tick(); chk("R9 preset 0 loads", count, 0);
    tick(); chk("R9 preset 0 wraps", count, 16'hFFFF);

    // R10 square wave
    do_prog(3'd3);
    do_load(16'd6);
    tick(); chk("R10 load", count, 6); chk("R10 out high", out, 1);
    tick(); chk("R10 step 2", count, 4);
    tick(); chk("R10 at 2", count, 2); chk("R10 out high", out, 1);
    tick(); chk("R10 reload", count, 6); chk("R10 toggle low", out, 0);
    tick(); tick(); tick(); chk("R10 reload 2", count, 6); chk("R10 toggle high", out, 1);
    do_load(16'd7);
    tick(); chk("R10 odd trimmed", count, 6);
    do_load(16'd0);
    tick(); chk("R10 preset 0", count, 16'hFFFE);
    tick(); chk("R10 preset 0 step", count, 16'hFFFC);
    do_load(16'd1);
    chk("R5 mode 3 refuses 1", load_err, 1);

    // R4 program clears
    do_prog(3'd0);
    chk("R4 count cleared", count, 0);
    chk("R4 err cleared", load_err, 0);
    chk("R4 out low mode 0", out, 0);
    tick(); chk("R4 no pending load", count, 0);

    // R8 one-shot
    do_prog(3'd1);
    do_load(16'd3);
    tick(); chk("R8 load alone no start", count, 0); chk("R8 out high idle", out, 1);
    set_gate(1'b0); set_gate(1'b1);
    tick(); chk("R8 trigger loads", count, 3); chk("R8 out low", out, 0);
    tick(); chk("R8 step", count, 2);
    set_gate(1'b0);
    tick(); chk("R8 gate level ignored", count, 1);
    set_gate(1'b1);
    tick(); chk("R8 retrigger", count, 3); chk("R8 out still low", out, 0);
    tick(); tick(); chk("R8 at 1", count, 1); chk("R8 out low", out, 0);
    tick(); chk("R8 at 0", count, 0); chk("R8 out high end", out, 1);
    tick(); chk("R8 halts", count, 0);

    // R8 gate-triggered strobe
    do_prog(3'd5);
    do_load(16'd2);
    set_gate(1'b0); set_gate(1'b1);
    tick(); chk("R8 strobe load", count, 2); chk("R8 strobe out high", out, 1);
    tick(); chk("R8 strobe step", count, 1);
    tick(); chk("R8 strobe 0", count, 0); chk("R8 strobe low", out, 0);
    tick(); chk("R8 strobe ends", out, 1);

    // random periodic runs: R9, R10
    for (int i = 0; i < 8; i++) begin
      int m, p;
      m = 2 + int'($urandom % 2);
      p = 2 + int'($urandom % 29);
      do_prog(3'(m));
      do_load(W'(p));
      for (int k = 0; k <= 2 * p; k++) begin
        tick();
        chk((m == 2) ? "R9 random count" : "R10 random count", count, 32'(exp_cnt(m, p, k)));
        chk((m == 2) ? "R9 random out" : "R10 random out", out, 32'(exp_out(m, p, k)));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule